// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets synchronous logic run single read and write cycles on an asynchronous byte-wide static RAM. The memory has 8192 byte locations on a 13-bit address. It is selected through two enables of opposite polarity, one active low and one active high. It also has an active-low output enable and an active-low write enable. Requests arrive through a valid/ready handshake that carries an address, write data and a write flag. Every transaction ends with a one-cycle response pulse. A read response carries the byte sampled from the memory; a write response carries no data.

All memory pin timing comes from cycle counts set by parameters. With the defaults and a 10 ns clock, a read holds the memory selected with output enable low for 100 ns before it samples. A write spends one cycle of address and data setup, then holds write enable low for 80 ns. After every cycle, one turnaround cycle keeps the address, and for writes the data, in place after the strobes release. The data bus is split into an output value, an output-enable and an input value.

A write-protect input stops new requests from being accepted. If it rises while a cycle is running, the controller releases every strobe at the next edge and reports the transaction with an error bit.

Top module: `sram_bus_ctrl`

## Requirements
- R1: In reset and after it, both selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0. With `wr_protect` low, `req_ready` is 1 once reset is released.
- R2: A read holds `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD_CYC cycles (default 10) and samples `mem_dq_in` at the end of the last one. It then gives a single-cycle `rsp_valid` with that byte on `rsp_rdata` and `rsp_err`=0.
- R3: A write drives both selects active for SETUP_CYC cycles (default 1) with `mem_we_n` high. It then holds `mem_we_n` low for exactly WE_CYC cycles (default 8). `mem_oe_n` is never low while `mem_we_n` is low.
- R4: During a write, `mem_dq_oe` is high from the setup cycle through the single cycle after `mem_we_n` rises, and low in the cycle after that.
- R5: `mem_addr` does not change while a select stays active. It keeps the request's address through the turnaround cycle after the strobes release.
- R6: `req_ready` is high only when the controller is idle and `wr_protect` is low. It drops in the cycle after a request is accepted.
- R7: While `wr_protect` is high and no cycle runs, no request is accepted and the memory pins stay inactive. A byte offered in that time never reaches the memory.
- R8: If `wr_protect` is high at an edge during a read, a write setup or a write strobe, every strobe is inactive after that edge. `rsp_valid` then pulses with `rsp_err`=1 and `rsp_rdata`=0. A write aborted during setup leaves the memory unchanged, and later requests run normally.
- R9: With requests presented back to back, the starts of consecutive select assertions are RD_CYC+2 cycles apart for reads (12) and SETUP_CYC+WE_CYC+2 cycles apart for writes (11).
- R10: A completed write gives a single-cycle `rsp_valid` with `rsp_err`=0 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_protect | input | 1 | Refuse new requests and abort the running cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte (0 for writes and aborts) |
| rsp_err | output | 1 | Transaction was aborted |
| mem_addr | output | 13 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The hardest conditions to reach from the ports are the abort windows. The single write-setup cycle is one clock wide and sits directly after the accepting edge. The mid-strobe window exists only while write enable is already low. The stimulus counts falling clock edges from the accepting edge and raises write protect in exactly the cycle it targets. It then reads the address back to show that an abort during setup left the memory untouched. The memory model returns a poison byte until output enable has been held for the full access time, so a shortened read shows up as wrong data.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_READ     = 3'd1,
        PH_WR_SETUP = 3'd2,
        PH_WR_PULSE = 3'd3,
        PH_TURN     = 3'd4
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
    } xact_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              sel_n;
        logic              sel;
        logic              oe_n;
        logic              we_n;
        logic [DATA_W-1:0] dq;
        logic              dq_oe;
    } pins_t;

    function automatic pins_t pins_quiet();
        pins_t p;
        p.addr  = '0;
        p.sel_n = 1'b1;
        p.sel   = 1'b0;
        p.oe_n  = 1'b1;
        p.we_n  = 1'b1;
        p.dq    = '0;
        p.dq_oe = 1'b0;
        return p;
    endfunction

    // Pin image for the phase the controller is entering.
    function automatic pins_t pins_for(phase_e ph, xact_t x);
        pins_t p;
        p      = pins_quiet();
        p.addr = x.addr;
        case (ph)
            PH_READ: begin
                p.sel_n = 1'b0;
                p.sel   = 1'b1;
                p.oe_n  = 1'b0;
            end
            PH_WR_SETUP: begin
                p.sel_n = 1'b0;
                p.sel   = 1'b1;
                p.dq_oe = 1'b1;
            end
            PH_WR_PULSE: begin
                p.sel_n = 1'b0;
                p.sel   = 1'b1;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            PH_TURN: begin
                p.dq_oe = x.wr;
            end
            default: ;
        endcase
        if (p.dq_oe) p.dq = x.wdata;
        return p;
    endfunction

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch
    import sram_bus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  xact_t d,
    output xact_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
    import sram_bus_pkg::*;
#(
    parameter int RD_CYC    = 10,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              wp,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output logic              accept,
    output phase_e            ph_nxt,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int MAX_CYC = (RD_CYC > WE_CYC) ?
                             ((RD_CYC > SETUP_CYC) ? RD_CYC : SETUP_CYC) :
                             ((WE_CYC > SETUP_CYC) ? WE_CYC : SETUP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e           ph;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             done, abort, sample, active;

    assign req_ready = (ph == PH_IDLE) && !wp;
    assign accept    = req_valid && req_ready;
    assign active    = (ph == PH_READ) || (ph == PH_WR_SETUP) || (ph == PH_WR_PULSE);

    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt;
        done    = 1'b0;
        abort   = 1'b0;
        sample  = 1'b0;
        case (ph)
            PH_IDLE: if (accept) begin
                ph_nxt  = req_write ? PH_WR_SETUP : PH_READ;
                cnt_nxt = req_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(RD_CYC - 1);
            end
            PH_READ: begin
                if (wp) begin
                    ph_nxt = PH_TURN;
                    abort  = 1'b1;
                end else if (cnt == '0) begin
                    ph_nxt = PH_TURN;
                    done   = 1'b1;
                    sample = 1'b1;
                end else cnt_nxt = cnt - 1'b1;
            end
            PH_WR_SETUP: begin
                if (wp) begin
                    ph_nxt = PH_TURN;
                    abort  = 1'b1;
                end else if (cnt == '0) begin
                    ph_nxt  = PH_WR_PULSE;
                    cnt_nxt = CNT_W'(WE_CYC - 1);
                end else cnt_nxt = cnt - 1'b1;
            end
            PH_WR_PULSE: begin
                if (wp) begin
                    ph_nxt = PH_TURN;
                    abort  = 1'b1;
                end else if (cnt == '0) begin
                    ph_nxt = PH_TURN;
                    done   = 1'b1;
                end else cnt_nxt = cnt - 1'b1;
            end
            PH_TURN: ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            ph        <= ph_nxt;
            cnt       <= cnt_nxt;
            rsp_valid <= done || abort;
            rsp_err   <= abort;
            rsp_rdata <= sample ? dq_in : '0;
        end
    end

    // R8: protect during a running cycle forces turnaround with an error response
    a_r8_abort_to_turn: assert property (@(posedge clk) disable iff (rst)
        (wp && active) |=> (ph == PH_TURN && rsp_valid && rsp_err));

    // R2: responses are single-cycle pulses
    a_r2_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6: an accepted request makes the controller busy
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_bus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e ph_nxt,
    input  xact_t  x,
    output pins_t  p
);
    always_ff @(posedge clk) begin
        if (rst) p <= pins_quiet();
        else     p <= pins_for(ph_nxt, x);
    end

    // R3: output enable stays off while the write strobe is low
    a_r3_no_oe_in_write: assert property (@(posedge clk) disable iff (rst)
        !p.we_n |-> p.oe_n);

    // R4: data is driven for the whole write strobe
    a_r4_data_under_we: assert property (@(posedge clk) disable iff (rst)
        !p.we_n |-> p.dq_oe);

    // R5: address frozen while the memory stays selected
    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (!p.sel_n && $past(!p.sel_n)) |-> $stable(p.addr));

    // R2: a strobe never rises out of an unselected state in the same edge as write
    a_r2_read_not_write: assert property (@(posedge clk) disable iff (rst)
        !p.oe_n |-> (p.we_n && !p.sel_n && p.sel));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int RD_CYC    = 10,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              wr_protect,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    xact_t  x_in, x_held, x_sel;
    phase_e ph_nxt;
    logic   accept;
    pins_t  pins;

    assign x_in  = '{addr: req_addr, wdata: req_wdata, wr: req_write};
    assign x_sel = accept ? x_in : x_held;

    sram_req_latch u_latch (
        .clk (clk),
        .rst (rst),
        .load(accept),
        .d   (x_in),
        .q   (x_held)
    );

    sram_cycle_fsm #(
        .RD_CYC   (RD_CYC),
        .SETUP_CYC(SETUP_CYC),
        .WE_CYC   (WE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .wp       (wr_protect),
        .dq_in    (mem_dq_in),
        .req_ready(req_ready),
        .accept   (accept),
        .ph_nxt   (ph_nxt),
        .rsp_valid(rsp_valid),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    sram_pin_drive u_pins (
        .clk   (clk),
        .rst   (rst),
        .ph_nxt(ph_nxt),
        .x     (x_sel),
        .p     (pins)
    );

    assign mem_addr   = pins.addr;
    assign mem_sel_n  = pins.sel_n;
    assign mem_sel    = pins.sel;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign mem_dq_out = pins.dq;
    assign mem_dq_oe  = pins.dq_oe;

endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;
    localparam int RD_CYC    = 10;
    localparam int SETUP_CYC = 1;
    localparam int WE_CYC    = 8;

    // {write, addr, data}; for reads data is the expected byte
    localparam logic [21:0] VEC [8] = '{
        {1'b1, 13'h0000, 8'hA5},
        {1'b1, 13'h1FFF, 8'h3C},
        {1'b1, 13'h0ABC, 8'h77},
        {1'b0, 13'h0000, 8'hA5},
        {1'b0, 13'h1FFF, 8'h3C},
        {1'b1, 13'h0ABC, 8'h81},
        {1'b0, 13'h0ABC, 8'h81},
        {1'b0, 13'h1FFF, 8'h3C}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, wr_protect = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    sram_bus_ctrl #(.RD_CYC(RD_CYC), .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .wr_protect(wr_protect), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: poison byte until the access time has elapsed
    logic [7:0] mem [bit [12:0]];
    logic [7:0] rd_val = 8'h00;
    int         rd_age = 0;
    wire rd_cond = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
    wire wr_cond = !mem_sel_n && mem_sel && !mem_we_n;

    always @(posedge clk) begin
        if (wr_cond) mem[mem_addr] = mem_dq_oe ? mem_dq_out : 8'hEE;
        rd_age <= rd_cond ? rd_age + 1 : 0;
    end
    always @(negedge clk) rd_val = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    assign mem_dq_in = (rd_cond && rd_age >= RD_CYC - 1) ? rd_val : 8'hEE;

    // Pin monitor, sampled on falling edges
    int we_run = 0, we_width = 0, rd_run = 0, rd_width = 0;
    int sel_gap = 0, last_gap = 0, overlap = 0, addr_moves = 0;
    logic dq_at_rise = 1'b0, dq_after = 1'b1, rise_pend = 1'b0, prev_sel_n = 1'b1;
    logic [12:0] prev_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                we_width = we_run; we_run = 0; dq_at_rise = mem_dq_oe; rise_pend = 1'b1;
            end else if (rise_pend) begin
                dq_after = mem_dq_oe; rise_pend = 1'b0;
            end
            if (rd_cond) rd_run++;
            else if (rd_run > 0) begin rd_width = rd_run; rd_run = 0; end
            sel_gap++;
            if (!mem_sel_n && prev_sel_n) begin last_gap = sel_gap; sel_gap = 0; end
            if (!mem_we_n && !mem_oe_n) overlap++;
            if (!mem_sel_n && !prev_sel_n && mem_addr != prev_addr) addr_moves++;
            prev_sel_n = mem_sel_n;
            prev_addr  = mem_addr;
        end
    end

    int  checks = 0, failures = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic xfer(input bit wr, input logic [12:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic er);
        int guard = 0;
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < 50000) begin @(posedge clk); wd++; end
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       er;
        logic       w;
        logic [12:0] a;
        logic [7:0] d;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(mem_sel_n == 1'b1, "R1 sel_n", mem_sel_n, 1);
        chk(mem_sel == 1'b0, "R1 sel", mem_sel, 0);
        chk(mem_oe_n && mem_we_n, "R1 oe_n/we_n", {mem_oe_n, mem_we_n}, 3);
        chk(!mem_dq_oe && !rsp_valid, "R1 dq_oe/rsp", {mem_dq_oe, rsp_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

        // Vector table walk (R2 R3 R4 R10)
        for (int i = 0; i < 8; i++) begin
            {w, a, d} = VEC[i];
            xfer(w, a, d, rd, er);
            if (w) begin
                chk(!er && rd == 8'h00, "R10 write rsp", {er, rd}, 0);
                settle(2);
                chk(we_width == WE_CYC, "R3 we width", we_width, WE_CYC);
                chk(dq_at_rise == 1'b1, "R4 data held after we", dq_at_rise, 1);
                chk(dq_after == 1'b0, "R4 data released", dq_after, 0);
            end else begin
                chk(!er && rd == d, "R2 read data", {er, rd}, {1'b0, d});
                settle(2);
                chk(rd_width == RD_CYC, "R2 read strobe width", rd_width, RD_CYC);
            end
        end
        chk(overlap == 0, "R3 oe during we", overlap, 0);
        chk(addr_moves == 0, "R5 address moved", addr_moves, 0);

        // R9 back-to-back spacing
        xfer(0, 13'h0001, 0, rd, er);
        xfer(0, 13'h0002, 0, rd, er);
        settle(1);
        chk(last_gap == RD_CYC + 2, "R9 read spacing", last_gap, RD_CYC + 2);
        xfer(1, 13'h0003, 8'h11, rd, er);
        xfer(1, 13'h0004, 8'h22, rd, er);
        settle(1);
        chk(last_gap == SETUP_CYC + WE_CYC + 2, "R9 write spacing", last_gap, SETUP_CYC + WE_CYC + 2);

        // R7 protect while idle
        settle(3);
        wr_protect = 1'b1;
        req_write = 1'b1; req_addr = 13'h0055; req_wdata = 8'hFF; req_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!req_ready && mem_sel_n, "R7 refused", {req_ready, mem_sel_n}, 1);
        end
        req_valid = 1'b0;
        @(negedge clk);
        wr_protect = 1'b0;
        xfer(0, 13'h0055, 0, rd, er);
        chk(rd == 8'h00 && !er, "R7 byte not written", rd, 0);

        // R8 abort a read
        settle(2);
        req_write = 1'b0; req_addr = 13'h1FFF; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R6 busy after accept", req_ready, 0);
        repeat (2) @(negedge clk);
        wr_protect = 1'b1;
        @(negedge clk);
        chk(mem_sel_n && mem_oe_n, "R8 read strobes off", {mem_sel_n, mem_oe_n}, 3);
        chk(rsp_valid && rsp_err && rsp_rdata == 0, "R8 read abort rsp",
            {rsp_valid, rsp_err, rsp_rdata}, 10'h300);
        wr_protect = 1'b0;

        // R8 abort a write during setup
        settle(3);
        req_write = 1'b1; req_addr = 13'h0ABC; req_wdata = 8'h99; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wr_protect = 1'b1;
        @(negedge clk);
        chk(mem_we_n && mem_sel_n, "R8 setup abort pins", {mem_we_n, mem_sel_n}, 3);
        chk(rsp_valid && rsp_err, "R8 setup abort rsp", {rsp_valid, rsp_err}, 3);
        wr_protect = 1'b0;
        xfer(0, 13'h0ABC, 0, rd, er);
        chk(rd == 8'h81 && !er, "R8 memory untouched", rd, 8'h81);

        // R8 abort a write in the strobe, then recover
        settle(2);
        req_write = 1'b1; req_addr = 13'h0100; req_wdata = 8'h42; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_we_n == 1'b0, "R3 strobe low mid-write", mem_we_n, 0);
        wr_protect = 1'b1;
        @(negedge clk);
        chk(mem_we_n && mem_sel_n, "R8 pulse abort pins", {mem_we_n, mem_sel_n}, 3);
        chk(rsp_valid && rsp_err, "R8 pulse abort rsp", {rsp_valid, rsp_err}, 3);
        wr_protect = 1'b0;
        xfer(1, 13'h0100, 8'h43, rd, er);
        chk(!er, "R10 write after abort", er, 0);
        xfer(0, 13'h0100, 0, rd, er);
        chk(rd == 8'h43 && !er, "R8 recovery read", rd, 8'h43);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule